// File: doc/BRIEF.md
# Dispatch Group Formation Checker

This block is a hazard oracle for an in-order scheduler. The scheduler packs instructions into groups of up to five slots. An external decoder reduces each candidate instruction to a four-bit class code and three flags:
- a count-register write marker;
- a branch-through-count-register marker;
- a load-overlap indication, produced by a companion address comparator.

From these inputs and the block's record of the group being built, the block returns a verdict in the same cycle. The verdict is one of three:
- accept: the candidate may join the current group.
- hazard: the group must be closed first.
- noop-hazard: a no-op slot should be inserted, because issuing now would force a pipeline flush.

The scheduler acts on the verdict with single-cycle strobes. It can commit the candidate, insert a no-op, advance a cycle, or flush the group. The block updates its per-unit occupancy counters, its slot count and its two structural markers. These are a count-register write seen in the group and a store seen in the group. When the group ends, the block clears all of them. A commit strobe given against a verdict other than accept leaves a sticky error flag raised.

Top module: `dgroup_checker`

## Requirements
- R1: Class codes are 0 pseudo, 1 fixed-point, 2 lead-only fixed-point (divide), 3 load, 4 store, 5 float, 6 condition-register, 7 special-register, 8 vector-ALU, 9 vector-permute and 10 branch. Codes 0 and 11 to 15 always give verdict accept and a commit of them changes no state. Verdicts are encoded 00 accept, 01 hazard and 10 noop-hazard; 11 never appears.
- R2: `slot_count` reports the slots used in the open group (0 to 4). A no-op insert or a cycle advance uses one slot. When a fifth slot is used, every counter and marker clears and `slot_count` returns to 0.
- R3: The per-group quotas are two fixed-point, two load/store, two float, and one each of condition-register, special-register, vector-ALU and vector-permute. A candidate whose unit has reached its quota gets hazard.
- R4: When four slots are used, every real class except branch gets hazard, and a branch may be accepted.
- R5: An accepted branch commit closes the group at once, whatever the slot count.
- R6: Condition-register, special-register and lead-only fixed-point candidates get hazard unless the group is empty.
- R7: A lead-only fixed-point commit counts against the fixed-point quota.
- R8: After a commit with `cand_ctr_write` set in the open group, a branch with `cand_ctr_branch` set gets noop-hazard. A branch without that flag does not. The marker lasts until the group ends.
- R9: A load with `cand_ld_overlap` set gets noop-hazard only when a store has been committed in the open group. Otherwise the load is accepted.
- R10: Synchronous active-high `rst` clears the group state and the error flag. `flush` clears the group state and keeps the error flag.
- R11: A commit strobe while the verdict is not accept sets `proto_err`, which stays set until reset, and the commit changes no group state.
- R12: The strobes act in priority order: flush, then commit, then no-op/advance. A no-op and an advance in the same cycle together use only one slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard the open group |
| cand_class | input | 4 | Candidate class code |
| cand_ctr_write | input | 1 | Candidate writes the count register |
| cand_ctr_branch | input | 1 | Candidate branches through the count register |
| cand_ld_overlap | input | 1 | Companion reports load/store address overlap |
| commit | input | 1 | Issue the candidate into the group |
| noop_ins | input | 1 | Insert a no-op slot |
| adv_cycle | input | 1 | Advance one cycle (uses a slot) |
| verdict | output | 2 | 00 accept, 01 hazard, 10 noop-hazard |
| slot_count | output | 3 | Slots used in the open group |
| proto_err | output | 1 | Sticky illegal-commit flag |

## Verification
Several strobes can arrive in the same cycle, so their interaction is tested on purpose. Commit is driven together with advance, no-op together with advance, and commit together with flush. The judgement is made on `slot_count` one edge later: it must be 1, one higher than before, and 0, in that order. A second clash is a commit strobe against a hazard verdict. After it, the slot count must stay unchanged while `proto_err` rises, and a later flush must keep the flag.

// File: rtl/dgc_pkg.sv
package dgc_pkg;

    localparam int NUNITS = 7;
    localparam int U_FIX  = 0;
    localparam int U_LDST = 1;
    localparam int U_FP   = 2;
    localparam int U_CREG = 3;
    localparam int U_SREG = 4;
    localparam int U_VALU = 5;
    localparam int U_VPRM = 6;

    localparam logic [3:0] CL_PSEUDO  = 4'd0;
    localparam logic [3:0] CL_FIX     = 4'd1;
    localparam logic [3:0] CL_FIXLEAD = 4'd2;
    localparam logic [3:0] CL_LOAD    = 4'd3;
    localparam logic [3:0] CL_STORE   = 4'd4;
    localparam logic [3:0] CL_FLOAT   = 4'd5;
    localparam logic [3:0] CL_CREG    = 4'd6;
    localparam logic [3:0] CL_SREG    = 4'd7;
    localparam logic [3:0] CL_VALU    = 4'd8;
    localparam logic [3:0] CL_VPERM   = 4'd9;
    localparam logic [3:0] CL_BRANCH  = 4'd10;

    typedef enum logic [1:0] {
        VD_ACCEPT = 2'b00,
        VD_HAZARD = 2'b01,
        VD_NOOP   = 2'b10
    } verdict_e;

    // True for every class that occupies a slot.
    function automatic logic is_real(input logic [3:0] c);
        return (c >= CL_FIX) && (c <= CL_BRANCH);
    endfunction

    // Classes that may only open a group.
    function automatic logic lead_only(input logic [3:0] c);
        return (c == CL_FIXLEAD) || (c == CL_CREG) || (c == CL_SREG);
    endfunction

    // One-hot selection of the execution unit a class draws on.
    function automatic logic [NUNITS-1:0] unit_mask(input logic [3:0] c);
        logic [NUNITS-1:0] m;
        m = '0;
        case (c)
            CL_FIX, CL_FIXLEAD: m[U_FIX]  = 1'b1;
            CL_LOAD, CL_STORE:  m[U_LDST] = 1'b1;
            CL_FLOAT:           m[U_FP]   = 1'b1;
            CL_CREG:            m[U_CREG] = 1'b1;
            CL_SREG:            m[U_SREG] = 1'b1;
            CL_VALU:            m[U_VALU] = 1'b1;
            CL_VPERM:           m[U_VPRM] = 1'b1;
            default:            m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dgc_quota_cmp.sv
module dgc_quota_cmp #(
    parameter int NUNITS = 7,
    parameter int QW     = 3,
    parameter logic [NUNITS-1:0][QW-1:0] QUOTA = '0
) (
    input  logic [NUNITS-1:0][QW-1:0] occ,
    output logic [NUNITS-1:0]         full
);

    for (genvar g = 0; g < NUNITS; g++) begin : g_unit
        assign full[g] = (occ[g] >= QUOTA[g]);
    end

endmodule

// File: rtl/dgc_verdict.sv
module dgc_verdict
    import dgc_pkg::*;
#(
    parameter int SLOTS = 5,
    parameter int SW    = 3
) (
    input  logic [3:0]        cls,
    input  logic              ctr_branch,
    input  logic              ld_overlap,
    input  logic [SW-1:0]     slots,
    input  logic [NUNITS-1:0] full,
    input  logic              ctr_set,
    input  logic              store_seen,
    output verdict_e          verdict
);

    localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);

    logic unit_full;

    always_comb begin
        unit_full = |(unit_mask(cls) & full);
        verdict   = VD_ACCEPT;
        if (!is_real(cls)) begin
            verdict = VD_ACCEPT;
        end else if (unit_full) begin
            verdict = VD_HAZARD;
        end else if (lead_only(cls) && (slots != '0)) begin
            verdict = VD_HAZARD;
        end else if ((slots == LAST_SLOT) && (cls != CL_BRANCH)) begin
            verdict = VD_HAZARD;
        end else if ((cls == CL_BRANCH) && ctr_branch && ctr_set) begin
            verdict = VD_NOOP;
        end else if ((cls == CL_LOAD) && ld_overlap && store_seen) begin
            verdict = VD_NOOP;
        end
    end

endmodule

// File: rtl/dgc_group_state.sv
module dgc_group_state
    import dgc_pkg::*;
#(
    parameter int SLOTS = 5,
    parameter int SW    = 3,
    parameter int QW    = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      flush,
    input  logic                      commit,
    input  logic                      noop_ins,
    input  logic                      adv_cycle,
    input  logic [3:0]                cls,
    input  logic                      ctr_write,
    input  verdict_e                  verdict,
    output logic [SW-1:0]             slots,
    output logic [NUNITS-1:0][QW-1:0] occ,
    output logic                      ctr_set,
    output logic                      store_seen,
    output logic                      err
);

    localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);

    typedef struct packed {
        logic [SW-1:0]             slots;
        logic [NUNITS-1:0][QW-1:0] occ;
        logic                      ctr_set;
        logic                      store_seen;
        logic                      err;
    } grp_t;

    grp_t grp_d, grp_q;
    logic [NUNITS-1:0] umask;

    always_comb begin
        grp_d = grp_q;
        umask = unit_mask(cls);
        if (commit && (verdict != VD_ACCEPT)) begin
            grp_d.err = 1'b1;
        end
        if (flush) begin
            grp_d.slots      = '0;
            grp_d.occ        = '0;
            grp_d.ctr_set    = 1'b0;
            grp_d.store_seen = 1'b0;
        end else if (commit) begin
            if ((verdict == VD_ACCEPT) && is_real(cls)) begin
                for (int u = 0; u < NUNITS; u++) begin
                    if (umask[u]) grp_d.occ[u] = grp_q.occ[u] + QW'(1);
                end
                if (ctr_write)         grp_d.ctr_set    = 1'b1;
                if (cls == CL_STORE)   grp_d.store_seen = 1'b1;
                if ((cls == CL_BRANCH) || (grp_q.slots == LAST_SLOT)) begin
                    grp_d.slots      = '0;
                    grp_d.occ        = '0;
                    grp_d.ctr_set    = 1'b0;
                    grp_d.store_seen = 1'b0;
                end else begin
                    grp_d.slots = grp_q.slots + SW'(1);
                end
            end
        end else if (noop_ins || adv_cycle) begin
            if (grp_q.slots == LAST_SLOT) begin
                grp_d.slots      = '0;
                grp_d.occ        = '0;
                grp_d.ctr_set    = 1'b0;
                grp_d.store_seen = 1'b0;
            end else begin
                grp_d.slots = grp_q.slots + SW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) grp_q <= '0;
        else     grp_q <= grp_d;
    end

    assign slots      = grp_q.slots;
    assign occ        = grp_q.occ;
    assign ctr_set    = grp_q.ctr_set;
    assign store_seen = grp_q.store_seen;
    assign err        = grp_q.err;

    // R10
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (slots == '0) && !err && !ctr_set && !store_seen);

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

endmodule

// File: rtl/dgroup_checker.sv
module dgroup_checker
    import dgc_pkg::*;
#(
    parameter int SLOTS        = 5,
    parameter int FIX_QUOTA    = 2,
    parameter int LDST_QUOTA   = 2,
    parameter int FP_QUOTA     = 2,
    parameter int SINGLE_QUOTA = 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        flush,
    input  logic [3:0]                  cand_class,
    input  logic                        cand_ctr_write,
    input  logic                        cand_ctr_branch,
    input  logic                        cand_ld_overlap,
    input  logic                        commit,
    input  logic                        noop_ins,
    input  logic                        adv_cycle,
    output logic [1:0]                  verdict,
    output logic [$clog2(SLOTS)-1:0]    slot_count,
    output logic                        proto_err
);

    localparam int SW = $clog2(SLOTS);
    localparam int QW = $clog2(SLOTS + 1);
    localparam logic [NUNITS-1:0][QW-1:0] QUOTA = {
        QW'(SINGLE_QUOTA), QW'(SINGLE_QUOTA), QW'(SINGLE_QUOTA),
        QW'(SINGLE_QUOTA), QW'(FP_QUOTA), QW'(LDST_QUOTA), QW'(FIX_QUOTA)
    };

    logic [SW-1:0]             slots;
    logic [NUNITS-1:0][QW-1:0] occ;
    logic [NUNITS-1:0]         full;
    logic                      ctr_set;
    logic                      store_seen;
    verdict_e                  vd;

    dgc_quota_cmp #(.NUNITS(NUNITS), .QW(QW), .QUOTA(QUOTA)) u_quota (
        .occ  (occ),
        .full (full)
    );

    dgc_verdict #(.SLOTS(SLOTS), .SW(SW)) u_verdict (
        .cls        (cand_class),
        .ctr_branch (cand_ctr_branch),
        .ld_overlap (cand_ld_overlap),
        .slots      (slots),
        .full       (full),
        .ctr_set    (ctr_set),
        .store_seen (store_seen),
        .verdict    (vd)
    );

    dgc_group_state #(.SLOTS(SLOTS), .SW(SW), .QW(QW)) u_state (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .commit     (commit),
        .noop_ins   (noop_ins),
        .adv_cycle  (adv_cycle),
        .cls        (cand_class),
        .ctr_write  (cand_ctr_write),
        .verdict    (vd),
        .slots      (slots),
        .occ        (occ),
        .ctr_set    (ctr_set),
        .store_seen (store_seen),
        .err        (proto_err)
    );

    assign verdict    = vd;
    assign slot_count = slots;

    // R1
    verdict_code_chk: assert property (@(posedge clk) disable iff (rst)
        verdict != 2'b11);

    // R1
    pseudo_still_chk: assert property (@(posedge clk) disable iff (rst)
        (commit && !is_real(cand_class) && !flush && !noop_ins && !adv_cycle)
        |=> $stable(slot_count));

    // R2
    slot_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(slot_count) < SLOTS);

    // R4
    last_slot_chk: assert property (@(posedge clk) disable iff (rst)
        ((int'(slot_count) == SLOTS - 1) && is_real(cand_class) &&
         (cand_class != CL_BRANCH)) |-> (verdict == VD_HAZARD));

    // R5
    branch_closes_chk: assert property (@(posedge clk) disable iff (rst)
        (commit && !flush && (cand_class == CL_BRANCH) && (verdict == VD_ACCEPT))
        |=> (slot_count == '0));

    // R6
    lead_chk: assert property (@(posedge clk) disable iff (rst)
        (lead_only(cand_class) && (slot_count != '0)) |-> (verdict == VD_HAZARD));

endmodule

// File: tb/dgroup_checker_test.sv
module dgroup_checker_test;
    import dgc_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst, flush, commit, noop_ins, adv_cycle;
    logic [3:0] cand_class;
    logic       cand_ctr_write, cand_ctr_branch, cand_ld_overlap;
    logic [1:0] verdict;
    logic [2:0] slot_count;
    logic       proto_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    dgroup_checker uut (
        .clk(clk), .rst(rst), .flush(flush), .cand_class(cand_class),
        .cand_ctr_write(cand_ctr_write), .cand_ctr_branch(cand_ctr_branch),
        .cand_ld_overlap(cand_ld_overlap), .commit(commit), .noop_ins(noop_ins),
        .adv_cycle(adv_cycle), .verdict(verdict), .slot_count(slot_count),
        .proto_err(proto_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Set candidate fields; caller sits just after a falling edge.
    task automatic put(input logic [3:0] c, input logic cw = 0,
                       input logic cb = 0, input logic ov = 0);
        cand_class = c; cand_ctr_write = cw; cand_ctr_branch = cb; cand_ld_overlap = ov;
        #1;
    endtask

    task automatic strobe(input logic c, input logic n, input logic a, input logic f);
        commit = c; noop_ins = n; adv_cycle = a; flush = f;
        @(posedge clk); #1;
        commit = 0; noop_ins = 0; adv_cycle = 0; flush = 0;
        @(negedge clk); #1;
    endtask

    task automatic issue(input logic [3:0] c, input logic cw = 0);
        put(c, cw);
        strobe(1, 0, 0, 0);
    endtask

    task automatic do_flush();
        strobe(0, 0, 0, 1);
    endtask

    task automatic t_reset();
        check("R10 reset slots", slot_count, 0);
        check("R10 reset err", proto_err, 0);
        put(CL_FIX);
        check("R1 verdict accept code", verdict, 0);
    endtask

    task automatic t_quota_last_slot();
        do_flush();
        issue(CL_FLOAT); issue(CL_FLOAT);
        check("R3 two floats", slot_count, 2);
        put(CL_FLOAT);
        check("R3 float quota hazard", verdict, 1);
        issue(CL_VALU);
        put(CL_VALU);
        check("R3 vector-ALU quota hazard", verdict, 1);
        issue(CL_VPERM);
        check("R4 four used", slot_count, 4);
        put(CL_FIX);
        check("R4 fixed at last slot hazard", verdict, 1);
        put(CL_BRANCH);
        check("R4 branch at last slot accept", verdict, 0);
        issue(CL_BRANCH);
        check("R5 branch closes full group", slot_count, 0);
        put(CL_FLOAT);
        check("R2 counters cleared", verdict, 0);
        issue(CL_FIX);
        issue(CL_BRANCH);
        check("R5 branch closes early", slot_count, 0);
        issue(CL_LOAD); issue(CL_STORE);
        put(CL_LOAD);
        check("R3 load/store quota hazard", verdict, 1);
    endtask

    task automatic t_lead();
        do_flush();
        issue(CL_FIX);
        put(CL_CREG);    check("R6 cond-reg after first", verdict, 1);
        put(CL_SREG);    check("R6 spec-reg after first", verdict, 1);
        put(CL_FIXLEAD); check("R6 divide after first", verdict, 1);
        do_flush();
        put(CL_FIXLEAD); check("R6 divide in empty group", verdict, 0);
        issue(CL_FIXLEAD);
        issue(CL_FIX);
        put(CL_FIX);     check("R7 divide counted in quota", verdict, 1);
    endtask

    task automatic t_ctr();
        do_flush();
        issue(CL_SREG, 1'b1);
        put(CL_BRANCH, 0, 1); check("R8 count branch noop", verdict, 2);
        put(CL_BRANCH, 0, 0); check("R8 plain branch accept", verdict, 0);
        strobe(0, 1, 0, 0);
        check("R2 noop uses slot", slot_count, 2);
        put(CL_BRANCH, 0, 1); check("R8 marker persists", verdict, 2);
        strobe(0, 0, 1, 0); strobe(0, 0, 1, 0);
        check("R2 advance uses slot", slot_count, 4);
        strobe(0, 0, 1, 0);
        check("R2 fifth slot clears", slot_count, 0);
        put(CL_BRANCH, 0, 1); check("R8 marker cleared", verdict, 0);
    endtask

    task automatic t_overlap();
        do_flush();
        put(CL_LOAD, 0, 0, 1); check("R9 overlap without store", verdict, 0);
        issue(CL_STORE);
        put(CL_LOAD, 0, 0, 1); check("R9 overlap after store", verdict, 2);
        put(CL_LOAD, 0, 0, 0); check("R9 no overlap", verdict, 0);
    endtask

    task automatic t_pseudo();
        do_flush();
        issue(CL_FIX);
        put(CL_PSEUDO); check("R1 pseudo accept", verdict, 0);
        strobe(1, 0, 0, 0);
        check("R1 pseudo no slot", slot_count, 1);
        put(4'd13); check("R1 unused code accept", verdict, 0);
        strobe(1, 0, 0, 0);
        check("R1 unused code no slot", slot_count, 1);
        check("R1 pseudo no error", proto_err, 0);
    endtask

    task automatic t_proto();
        do_flush();
        issue(CL_FIX); issue(CL_FIX);
        put(CL_FIX);
        strobe(1, 0, 0, 0);
        check("R11 rejected commit no change", slot_count, 2);
        check("R11 error raised", proto_err, 1);
        do_flush();
        check("R10 flush clears slots", slot_count, 0);
        check("R10 flush keeps error", proto_err, 1);
    endtask

    task automatic t_priority();
        do_flush();
        put(CL_FIX);
        strobe(1, 0, 1, 0);
        check("R12 commit beats advance", slot_count, 1);
        strobe(0, 1, 1, 0);
        check("R12 noop and advance one slot", slot_count, 2);
        put(CL_FIX);
        strobe(1, 0, 0, 1);
        check("R12 flush beats commit", slot_count, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; flush = 0; commit = 0; noop_ins = 0; adv_cycle = 0;
        cand_class = CL_PSEUDO; cand_ctr_write = 0; cand_ctr_branch = 0; cand_ld_overlap = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0; #1;
        t_reset();
        t_quota_last_slot();
        t_lead();
        t_ctr();
        t_overlap();
        t_pseudo();
        t_proto();
        t_priority();
        rst = 1;
        @(posedge clk); #1;
        @(negedge clk); rst = 0; #1;
        check("R10 reset clears error", proto_err, 0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule